// File: doc/BRIEF.md
# I/O-Windowed Scratch RAM Interface

This block lets a CPU on an 8-bit expansion bus with a 16-bit I/O address reach an 8 KB scratch RAM through I/O cycles only. The 13-bit RAM address is assembled from two parts. A four-bit page register is loaded by a write to the page port group. The nine low bits come from the I/O address of a cycle to the data window port group. That cycle then reads or writes one byte.

Between the bus and the RAM pins, both the address and the data bits are rearranged by fixed permutations. Each permutation is a parameter. The read path applies the exact inverse of the data permutation, so software sees its own byte back. The window is gated by a freeze-mode input: while freeze is low, window writes never reach the RAM and window reads leave the bus undriven. The RAM itself sits outside the block as an asynchronous static array wired to the scrambled pins.

Top module: `io_scratch_ram`

## Requirements
- R1: An I/O cycle whose address bits 15..9 equal 1111110 (ports FC00..FDFF) is a window cycle. With freeze high, a window write asserts ram_we and a window read asserts ram_re, both in the same cycle.
- R2: An I/O write whose address bits 15..9 equal 1111111 (ports FE00..FFFF) loads wdata bits 3..0 into the page register. The I/O address bits 8..0 and wdata bits 7..4 have no effect. The load happens whatever the freeze level.
- R3: After reset the page register is zero.
- R4: The logical RAM address is {page[3:0], io_addr[8:0]}. RAM pin ram_a[i] carries logical bit AMAP[i], where AMAP for i=0..12 is 7,2,11,0,9,4,12,1,6,10,3,8,5.
- R5: RAM pin ram_d[i] carries wdata bit DMAP[i], where DMAP for i=0..7 is 3,6,0,7,1,4,2,5.
- R6: A window read captures ram_q at the clock edge and presents it on rdata with bus bit DMAP[i] taken from ram_q[i], with rdata_oe high, in the cycle after the read. A write followed by a read of the same port with the same page returns the written byte.
- R7: While freeze is low, window writes leave ram_we low and the RAM unchanged. Window reads leave rdata_oe low and rdata zero.
- R8: I/O cycles to any port outside FC00..FFFF leave ram_we, ram_re and rdata_oe low, and do not change the page register.
- R9: Different page values with the same window port reach distinct RAM locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address of the current cycle |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe, one cycle |
| wdata | input | 8 | CPU write data |
| freeze | input | 1 | Freeze mode active; enables the window |
| rdata | output | 8 | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data drive enable |
| ram_a | output | 13 | Scrambled RAM address pins |
| ram_d | output | 8 | Scrambled RAM write data pins |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_q | input | 8 | Scrambled RAM read data pins |

## Verification
The page register has no read-back path. Its value can only be observed through the scrambled address pins during a later window cycle. Proving that an ignored cycle left it untouched therefore needs a page write, then the disturbing cycle, then a window access whose pin address is checked against the bench's own scramble of the expected page. Bank separation is shown by writing two different bytes under two page values at one port and reading both back through a bench RAM model keyed by the pin address.

// File: rtl/scratch_pkg.sv
package scratch_pkg;
   localparam int BUS_AW  = 16;
   localparam int WIN_LOW = 9;
   localparam int PAGE_W  = 4;
   localparam int BYTE_W  = 8;

   typedef enum logic [1:0] {
      PSEL_NONE   = 2'd0,
      PSEL_WINDOW = 2'd1,
      PSEL_PAGE   = 2'd2
   } port_sel_e;

   // default scrambles: pin i takes logical bit MAP[i]
   localparam logic [BYTE_W*3-1:0] DEF_DMAP =
      {3'd5, 3'd2, 3'd4, 3'd1, 3'd7, 3'd0, 3'd6, 3'd3};
   localparam logic [13*4-1:0] DEF_AMAP =
      {4'd5, 4'd8, 4'd3, 4'd10, 4'd6, 4'd1, 4'd12, 4'd4, 4'd9, 4'd0, 4'd11, 4'd2, 4'd7};
endpackage

// File: rtl/port_decoder.sv
module port_decoder
   import scratch_pkg::*;
#(
   parameter int AW      = 16,
   parameter int LOW_W   = 9,
   parameter int TAG_W   = AW - LOW_W,
   parameter logic [TAG_W-1:0] WIN_TAG  = 7'h7E,
   parameter logic [TAG_W-1:0] PAGE_TAG = 7'h7F
) (
   input  logic [AW-1:0] io_addr,
   output port_sel_e     sel
);
   if (TAG_W < 1) begin : g_bad_tag
      $error("port_decoder: no tag bits left above window");
   end
   if (WIN_TAG == PAGE_TAG) begin : g_bad_overlap
      $error("port_decoder: window and page tags collide");
   end

   logic [TAG_W-1:0] tag;
   assign tag = io_addr[AW-1:LOW_W];

   always_comb begin
      if (tag == WIN_TAG)       sel = PSEL_WINDOW;
      else if (tag == PAGE_TAG) sel = PSEL_PAGE;
      else                      sel = PSEL_NONE;
   end
endmodule

// File: rtl/page_latch.sv
module page_latch #(
   parameter int W = 4,
   parameter int SRC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SRC_W-1:0] src,
   output logic [W-1:0]     page
);
   if (W > SRC_W) begin : g_bad_width
      $error("page_latch: page wider than data bus");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    page <= '0;
      else if (load) page <= src[W-1:0];
   end

   AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> page == $past(src[W-1:0])); // R2
   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(page)); // R8
endmodule

// File: rtl/bit_scrambler.sv
module bit_scrambler #(
   parameter int W = 8,
   parameter int IW = (W > 1) ? $clog2(W) : 1,
   parameter logic [W*IW-1:0] MAP = '0,
   parameter bit INVERSE = 1'b0
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   function automatic bit map_is_perm();
      bit [W-1:0] seen;
      seen = '0;
      for (int i = 0; i < W; i++) begin
         int unsigned idx;
         idx = int'(MAP[i*IW +: IW]);
         if (idx >= W) return 1'b0;
         if (seen[idx]) return 1'b0;
         seen[idx] = 1'b1;
      end
      return 1'b1;
   endfunction

   localparam bit MAP_OK = map_is_perm();

   if (W < 2) begin : g_bad_w
      $error("bit_scrambler: width below two");
   end
   if (!MAP_OK) begin : g_bad_map
      $error("bit_scrambler: MAP is not a permutation");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      localparam int SRC = int'(MAP[i*IW +: IW]);
      if (INVERSE) begin : g_inv
         assign dout[SRC] = din[i];
      end else begin : g_fwd
         assign dout[i] = din[SRC];
      end
   end
endmodule

// File: rtl/io_scratch_ram.sv
module io_scratch_ram
   import scratch_pkg::*;
#(
   parameter int AW     = BUS_AW,
   parameter int LOW_W  = WIN_LOW,
   parameter int PG_W   = PAGE_W,
   parameter int DW     = BYTE_W,
   parameter int RAM_AW = LOW_W + PG_W,
   parameter logic [RAM_AW*$clog2(RAM_AW)-1:0] AMAP = DEF_AMAP,
   parameter logic [DW*$clog2(DW)-1:0]         DMAP = DEF_DMAP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DW-1:0]     wdata,
   input  logic              freeze,
   output logic [DW-1:0]     rdata,
   output logic              rdata_oe,
   output logic [RAM_AW-1:0] ram_a,
   output logic [DW-1:0]     ram_d,
   output logic              ram_we,
   output logic              ram_re,
   input  logic [DW-1:0]     ram_q
);
   localparam int TAG_W = AW - LOW_W;

   if (RAM_AW != LOW_W + PG_W) begin : g_bad_ram_aw
      $error("io_scratch_ram: RAM_AW must equal LOW_W + PG_W");
   end

   port_sel_e          sel;
   logic [PG_W-1:0]    page;
   logic [RAM_AW-1:0]  logical_a;
   logic [DW-1:0]      q_bus;
   logic [DW-1:0]      rdata_q;
   logic               win_hit;
   logic               page_load;

   port_decoder #(
      .AW(AW), .LOW_W(LOW_W), .TAG_W(TAG_W),
      .WIN_TAG({{(TAG_W-1){1'b1}}, 1'b0}),
      .PAGE_TAG({TAG_W{1'b1}})
   ) u_dec (
      .io_addr(io_addr),
      .sel    (sel)
   );

   assign win_hit   = (sel == PSEL_WINDOW) && freeze;
   assign page_load = (sel == PSEL_PAGE) && io_wr;

   page_latch #(.W(PG_W), .SRC_W(DW)) u_page (
      .clk  (clk),
      .rst_n(rst_n),
      .load (page_load),
      .src  (wdata),
      .page (page)
   );

   assign logical_a = {page, io_addr[LOW_W-1:0]};

   bit_scrambler #(.W(RAM_AW), .MAP(AMAP), .INVERSE(1'b0)) u_ascr (
      .din (logical_a),
      .dout(ram_a)
   );

   bit_scrambler #(.W(DW), .MAP(DMAP), .INVERSE(1'b0)) u_dscr (
      .din (wdata),
      .dout(ram_d)
   );

   bit_scrambler #(.W(DW), .MAP(DMAP), .INVERSE(1'b1)) u_dunscr (
      .din (ram_q),
      .dout(q_bus)
   );

   assign ram_we = win_hit && io_wr;
   assign ram_re = win_hit && io_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rdata_oe <= 1'b0;
      end else begin
         rdata_oe <= ram_re;
         rdata_q  <= ram_re ? q_bus : '0;
      end
   end

   assign rdata = rdata_q;

   AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      !freeze |-> !ram_we && !ram_re); // R7
   AST_OE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re |=> rdata_oe); // R6
   AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> $past(io_rd) && $past(freeze)); // R6
   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> rdata == '0); // R7
   AST_NO_STRAY_WE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> io_addr[AW-1:LOW_W+1] == {(TAG_W-1){1'b1}}); // R8
endmodule

// File: tb/io_scratch_ram_test.sv
`timescale 1ns/1ps
module io_scratch_ram_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] io_addr = 0;
   logic        io_wr = 0, io_rd = 0;
   logic [7:0]  wdata = 0;
   logic        freeze = 0;
   logic [7:0]  rdata;
   logic        rdata_oe;
   logic [12:0] ram_a;
   logic [7:0]  ram_d;
   logic        ram_we, ram_re;
   logic [7:0]  ram_q = 0;

   int checks = 0, errors = 0;
   int amap [13] = '{7, 2, 11, 0, 9, 4, 12, 1, 6, 10, 3, 8, 5};
   int dmap [8]  = '{3, 6, 0, 7, 1, 4, 2, 5};
   logic [7:0] mem [int];
   int mem_gen = 0;

   always #2 clk = ~clk;

   io_scratch_ram uut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .wdata(wdata), .freeze(freeze), .rdata(rdata), .rdata_oe(rdata_oe),
      .ram_a(ram_a), .ram_d(ram_d), .ram_we(ram_we), .ram_re(ram_re), .ram_q(ram_q)
   );

   // asynchronous RAM model on the scrambled pins
   always @(posedge clk) if (ram_we) begin
      mem[int'(ram_a)] = ram_d;
      mem_gen++;
   end
   always begin
      @(ram_a or mem_gen);
      ram_q = mem.exists(int'(ram_a)) ? mem[int'(ram_a)] : 8'h00;
   end

   function automatic logic [12:0] scr_a(input logic [12:0] l);
      logic [12:0] r;
      for (int i = 0; i < 13; i++) r[i] = l[amap[i]];
      return r;
   endfunction
   function automatic logic [7:0] scr_d(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[dmap[i]];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; wdata = d; io_wr = 1;
      @(posedge clk); #1;
      @(negedge clk);
      io_wr = 0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      io_addr = a; io_rd = 1;
      @(posedge clk); #1;
      d = rdata; oe = rdata_oe;
      @(negedge clk);
      io_rd = 0;
   endtask

   // window write with pin check in the same cycle
   task automatic win_write_pins(input logic [3:0] pg, input logic [15:0] a,
                                 input logic [7:0] d, input string req);
      @(negedge clk);
      io_addr = a; wdata = d; io_wr = 1;
      #1;
      chk({req, " ram_we"}, ram_we, freeze);
      chk({req, " ram_a"}, ram_a, scr_a({pg, a[8:0]}));
      chk({req, " ram_d"}, ram_d, scr_d(d));
      @(posedge clk); #1;
      @(negedge clk);
      io_wr = 0;
   endtask

   task automatic t_reset;
      logic [7:0] d; logic oe;
      chk("R3 oe at reset", rdata_oe, 0);
      chk("R3 rdata at reset", rdata, 0);
      freeze = 1;
      @(negedge clk);
      io_addr = 16'hFD5A; io_rd = 1; #1;
      chk("R3 page zero on pins", ram_a, scr_a({4'h0, 9'h15A}));
      chk("R1 ram_re on window read", ram_re, 1);
      @(negedge clk); io_rd = 0;
   endtask

   task automatic t_page_decode;
      io_write(16'hFE5A, 8'hF3);     // low address bits and high data bits ignored
      win_write_pins(4'h3, 16'hFC07, 8'h81, "R2 page load");
      io_write(16'hFFFF, 8'h0C);
      win_write_pins(4'hC, 16'hFD00, 8'h5A, "R4 scrambled address");
      freeze = 0;
      io_write(16'hFE00, 8'h06);     // load while frozen off
      freeze = 1;
      win_write_pins(4'h6, 16'hFC00, 8'hA5, "R2 page load with freeze low");
   endtask

   task automatic t_data_scramble;
      io_write(16'hFE00, 8'h00);
      win_write_pins(4'h0, 16'hFC01, 8'h01, "R5 data bit");
      win_write_pins(4'h0, 16'hFC02, 8'h80, "R5 data bit");
      win_write_pins(4'h0, 16'hFC03, 8'h55, "R5 data pattern");
   endtask

   task automatic t_roundtrip;
      logic [7:0] d; logic oe;
      io_write(16'hFE00, 8'h02);
      io_write(16'hFC33, 8'h55);
      io_read(16'hFC33, d, oe);
      chk("R6 oe", oe, 1);
      chk("R6 readback 55", d, 8'h55);
      io_write(16'hFDFF, 8'hC9);
      io_read(16'hFDFF, d, oe);
      chk("R6 readback C9", d, 8'hC9);
      @(negedge clk); #1;
      chk("R6 oe drops", rdata_oe, 0);
   endtask

   task automatic t_freeze_gate;
      logic [7:0] d; logic oe;
      io_write(16'hFE00, 8'h01);
      io_write(16'hFC20, 8'h77);
      freeze = 0;
      win_write_pins(4'h1, 16'hFC20, 8'h11, "R7 write blocked");
      io_read(16'hFC20, d, oe);
      chk("R7 oe low", oe, 0);
      chk("R7 rdata zero", d, 0);
      freeze = 1;
      io_read(16'hFC20, d, oe);
      chk("R7 content unchanged", d, 8'h77);
   endtask

   task automatic t_other_ports;
      logic [7:0] d; logic oe;
      io_write(16'hFE00, 8'h09);
      @(negedge clk);
      io_addr = 16'h7C10; wdata = 8'h05; io_wr = 1; #1;
      chk("R8 no we for 7C10", ram_we, 0);
      @(negedge clk);
      io_addr = 16'hFA10; io_wr = 0; io_rd = 1; #1;
      chk("R8 no re for FA10", ram_re, 0);
      @(posedge clk); #1;
      chk("R8 no oe for FA10", rdata_oe, 0);
      @(negedge clk); io_rd = 0;
      io_write(16'h7E00, 8'h04);      // page-like but bit 15 low
      win_write_pins(4'h9, 16'hFC10, 8'h3C, "R8 page untouched");
   endtask

   task automatic t_banks;
      logic [7:0] d; logic oe;
      io_write(16'hFE00, 8'h05);
      io_write(16'hFC44, 8'hAA);
      io_write(16'hFE00, 8'h0A);
      io_write(16'hFC44, 8'hBB);
      io_write(16'hFE00, 8'h05);
      io_read(16'hFC44, d, oe);
      chk("R9 page 5 byte", d, 8'hAA);
      io_write(16'hFE00, 8'h0A);
      io_read(16'hFC44, d, oe);
      chk("R9 page A byte", d, 8'hBB);
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      t_reset();
      t_page_decode();
      t_data_scramble();
      t_roundtrip();
      t_freeze_gate();
      t_other_ports();
      t_banks();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule